// File: doc/BRIEF.md
# Power-Change System Management Interrupt Generator

This block raises a system management interrupt (SMI) when software programs a power change for a card socket. It watches two write strobes: one for the card socket control register and one for the legacy power control register. It also watches an indication from the power switch logic that a power-cycle change sequence has just been launched. A write counts as an event only when it arrives in the same cycle as that launch indication. A write that leaves the power setting unchanged launches no sequence, so it records nothing.

Each event sets a sticky status flag. Software clears the flag by writing a 1 to it. An enable bit decides whether a set flag drives the interrupt. A route bit sends the interrupt either to a dedicated SMI pin or to the serialized interrupt stream. All three control bits sit in one 32-bit system control word. Software writes them through a configuration write port and reads them back through the same word.

Top module: `power_smi_gen`

## Requirements
- R1: After reset, enable, status and route are 0, both SMI outputs are low and the readback word is zero.
- R2: A card socket control write (`sock_wr_i`) in the same cycle as `seq_start_i` sets the status flag, which reads as 1 from the following cycle.
- R3: A legacy power control write (`pwr_wr_i`) in the same cycle as `seq_start_i` sets the status flag, which reads as 1 from the following cycle.
- R4: A register write without `seq_start_i` in that cycle leaves the status flag unchanged.
- R5: `seq_start_i` without either write strobe in that cycle leaves the status flag unchanged.
- R6: Both write strobes together with `seq_start_i` record a single event. One write-1-to-clear afterwards leaves the flag clear.
- R7: The status flag stays set until software clears it. A configuration write with bit 25 at 0 does not clear it.
- R8: A configuration write with bit 25 at 1 clears the status flag. If an event occurs in the same cycle, the flag stays set.
- R9: An SMI output is high only while both the status flag and the enable bit (bit 24) are 1. Clearing the enable drops the output but keeps the flag.
- R10: With the route bit (bit 26) at 0 the SMI appears on `smi_pin_o`. With it at 1 the SMI appears on `smi_serial_o`. The unselected output stays low.
- R11: The readback word carries enable at bit 24, status at bit 25 and route at bit 26, and all other bits are 0.
- R12: A configuration write loads enable from bit 24 and route from bit 26 of the write data. These bits keep their values while no configuration write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sock_wr_i | input | 1 | Write strobe for the card socket control register |
| pwr_wr_i | input | 1 | Write strobe for the legacy power control register |
| seq_start_i | input | 1 | Power switch sequence launched this cycle |
| cfg_wr_i | input | 1 | Write strobe for the system control word |
| cfg_wdata_i | input | 32 | System control write data |
| cfg_rdata_o | output | 32 | System control readback |
| smi_pin_o | output | 1 | SMI on the dedicated pin path |
| smi_serial_o | output | 1 | SMI request toward the serialized interrupt stream |

## Verification
The bench aims at a clear and a new event landing in the same cycle. A design that gives the clear priority would lose that event and leave the flag low. It also writes with bit 25 at 0 to confirm the flag survives. A design that treated any write as a clear would drop the flag there.

Writes without the launch indication, and launch indications without a write, must leave the flag alone. A design that triggers on either signal alone would set status where none is due. Route and enable are toggled while the flag is held, to check two things. The unselected output must never follow the interrupt. Disabling must silence the output without erasing the flag.

// File: rtl/smi_pkg.sv
package smi_pkg;

   typedef enum logic {
      ROUTE_PIN    = 1'b0,
      ROUTE_SERIAL = 1'b1
   } smi_route_e;

   typedef struct packed {
      logic       enable;
      logic       status;
      smi_route_e route;
   } smi_ctl_t;

endpackage

// File: rtl/smi_trigger.sv
module smi_trigger #(
   parameter int NSRC = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] wr_i,
   input  logic            seq_start_i,
   output logic            event_o
);

   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("smi_trigger: NSRC must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] hit;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign hit[i] = wr_i[i] & seq_start_i;
      end
   endgenerate

   // any number of simultaneous sources folds into one event
   assign event_o = |hit;

   // R4
   no_launch_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seq_start_i |-> !event_o);

   // R5
   no_write_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i == '0) |-> !event_o);

endmodule

// File: rtl/smi_ctl_reg.sv
module smi_ctl_reg
   import smi_pkg::*;
#(
   parameter int CFG_W   = 32,
   parameter int EN_BIT  = 24,
   parameter int STS_BIT = 25,
   parameter int RTE_BIT = 26
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             event_i,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output smi_ctl_t         ctl_o,
   output logic [CFG_W-1:0] cfg_rdata_o
);

   generate
      if (EN_BIT >= CFG_W || STS_BIT >= CFG_W || RTE_BIT >= CFG_W) begin : g_bad_pos
         $error("smi_ctl_reg: control bit outside the word");
      end
      if (EN_BIT == STS_BIT || EN_BIT == RTE_BIT || STS_BIT == RTE_BIT) begin : g_bad_overlap
         $error("smi_ctl_reg: control bits overlap");
      end
   endgenerate

   smi_ctl_t ctl_q;
   logic     clr_req;

   assign clr_req = cfg_wr_i & cfg_wdata_i[STS_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q.enable <= 1'b0;
         ctl_q.route  <= ROUTE_PIN;
      end else if (cfg_wr_i) begin
         ctl_q.enable <= cfg_wdata_i[EN_BIT];
         ctl_q.route  <= smi_route_e'(cfg_wdata_i[RTE_BIT]);
      end
   end

   // a new event outranks a simultaneous clear so no event is lost
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ctl_q.status <= 1'b0;
      else if (event_i)  ctl_q.status <= 1'b1;
      else if (clr_req)  ctl_q.status <= 1'b0;
   end

   assign ctl_o = ctl_q;

   always_comb begin
      cfg_rdata_o          = '0;
      cfg_rdata_o[EN_BIT]  = ctl_q.enable;
      cfg_rdata_o[STS_BIT] = ctl_q.status;
      cfg_rdata_o[RTE_BIT] = ctl_q.route;
   end

   // R2
   event_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i |=> ctl_q.status);

   // R8
   w1c_clears_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i && cfg_wr_i && cfg_wdata_i[STS_BIT]) |=> !ctl_q.status);

   // R7
   status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i && !(cfg_wr_i && cfg_wdata_i[STS_BIT])) |=> $stable(ctl_q.status));

   // R12
   ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_wr_i |=> ($stable(ctl_q.enable) && $stable(ctl_q.route)));

endmodule

// File: rtl/smi_route.sv
module smi_route
   import smi_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  smi_ctl_t ctl_i,
   output logic     smi_pin_o,
   output logic     smi_serial_o
);

   logic active;
   logic pin_d, ser_d;

   assign active = ctl_i.status & ctl_i.enable;
   assign pin_d  = active & (ctl_i.route == ROUTE_PIN);
   assign ser_d  = active & (ctl_i.route == ROUTE_SERIAL);

   generate
      if (OUT_REG) begin : g_reg
         logic pin_q, ser_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pin_q <= 1'b0;
               ser_q <= 1'b0;
            end else begin
               pin_q <= pin_d;
               ser_q <= ser_d;
            end
         end
         assign smi_pin_o    = pin_q;
         assign smi_serial_o = ser_q;
      end else begin : g_comb
         assign smi_pin_o    = pin_d;
         assign smi_serial_o = ser_d;

         // R9
         smi_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(ctl_i.enable && ctl_i.status) |-> !(smi_pin_o || smi_serial_o));
      end
   endgenerate

   // R10
   one_path_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({smi_pin_o, smi_serial_o}));

endmodule

// File: rtl/power_smi_gen.sv
module power_smi_gen
   import smi_pkg::*;
#(
   parameter int CFG_W   = 32,
   parameter int EN_BIT  = 24,
   parameter int STS_BIT = 25,
   parameter int RTE_BIT = 26,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sock_wr_i,
   input  logic             pwr_wr_i,
   input  logic             seq_start_i,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output logic [CFG_W-1:0] cfg_rdata_o,
   output logic             smi_pin_o,
   output logic             smi_serial_o
);

   localparam int NSRC = 2;

   logic     evt;
   smi_ctl_t ctl;

   smi_trigger #(.NSRC(NSRC)) u_trig (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        ({pwr_wr_i, sock_wr_i}),
      .seq_start_i (seq_start_i),
      .event_o     (evt)
   );

   smi_ctl_reg #(
      .CFG_W   (CFG_W),
      .EN_BIT  (EN_BIT),
      .STS_BIT (STS_BIT),
      .RTE_BIT (RTE_BIT)
   ) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .event_i     (evt),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_wdata_i (cfg_wdata_i),
      .ctl_o       (ctl),
      .cfg_rdata_o (cfg_rdata_o)
   );

   smi_route #(.OUT_REG(OUT_REG)) u_route (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctl_i        (ctl),
      .smi_pin_o    (smi_pin_o),
      .smi_serial_o (smi_serial_o)
   );

   // R3
   pwr_write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_wr_i && seq_start_i) |=> cfg_rdata_o[STS_BIT]);

endmodule

// File: tb/tb_power_smi_gen.sv
module tb_power_smi_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sock_wr = 0, pwr_wr = 0, seq = 0, cfg_wr = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pin, ser;

   int checks = 0;
   int errors = 0;

   // bench model of the control bits
   bit m_en, m_sts, m_rte;

   always #2.5 clk = ~clk;

   power_smi_gen dut (
      .clk_i(clk), .rst_ni(rst_n),
      .sock_wr_i(sock_wr), .pwr_wr_i(pwr_wr), .seq_start_i(seq),
      .cfg_wr_i(cfg_wr), .cfg_wdata_i(wdata),
      .cfg_rdata_o(rdata), .smi_pin_o(pin), .smi_serial_o(ser)
   );

   function automatic logic [31:0] f_rdata(bit en, bit sts, bit rte);
      logic [31:0] r = '0;
      r[24] = en; r[25] = sts; r[26] = rte;
      return r;
   endfunction

   function automatic bit f_pin(bit en, bit sts, bit rte);
      return en && sts && !rte;
   endfunction

   function automatic bit f_ser(bit en, bit sts, bit rte);
      return en && sts && rte;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk({req, " rdata"}, rdata, f_rdata(m_en, m_sts, m_rte));
      chk({req, " pin"},   {31'd0, pin}, {31'd0, f_pin(m_en, m_sts, m_rte)});
      chk({req, " serial"},{31'd0, ser}, {31'd0, f_ser(m_en, m_sts, m_rte)});
   endtask

   // drive one cycle at negedge, update model across posedge, sample at next negedge
   task automatic step(bit s, bit p, bit q, bit c, logic [31:0] d, string req);
      sock_wr = s; pwr_wr = p; seq = q; cfg_wr = c; wdata = d;
      @(negedge clk);
      if ((s || p) && q)  m_sts = 1;
      else if (c && d[25]) m_sts = 0;
      if (c) begin m_en = d[24]; m_rte = d[26]; end
      sock_wr = 0; pwr_wr = 0; seq = 0; cfg_wr = 0;
      check_all(req);
   endtask

   function automatic logic [31:0] cw(bit en, bit clr, bit rte, logic [31:0] noise);
      logic [31:0] r = noise;
      r[24] = en; r[25] = clr; r[26] = rte;
      return r;
   endfunction

   initial begin
      #500us;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4510));
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      step(1, 0, 0, 0, '0, "R4");                        // write, no launch
      step(0, 1, 0, 0, '0, "R4");
      step(0, 0, 1, 0, '0, "R5");                        // launch, no write
      step(0, 0, 0, 1, cw(1, 0, 0, 32'h0), "R12");       // enable, route pin
      step(1, 0, 1, 0, '0, "R2");                        // socket event -> pin
      step(0, 0, 0, 1, cw(1, 0, 1, 32'hFFFF_FFFF & ~32'h0700_0000), "R7"); // no clear, route serial
      step(0, 0, 0, 0, '0, "R10");
      step(0, 0, 0, 1, cw(0, 0, 1, 32'h0), "R9");        // disable, status kept
      step(0, 0, 0, 1, cw(1, 1, 0, 32'h0), "R8");        // clear
      step(0, 1, 1, 0, '0, "R3");                        // legacy event
      step(0, 1, 1, 1, cw(1, 1, 0, 32'h0), "R8");        // event beats clear
      step(0, 0, 0, 1, cw(1, 1, 0, 32'h0), "R8");
      step(1, 1, 1, 0, '0, "R6");                        // both sources at once
      step(0, 0, 0, 1, cw(1, 1, 0, 32'h0), "R6");
      step(0, 0, 0, 0, '0, "R6");
      step(0, 0, 0, 1, cw(1, 0, 1, 32'h1234_5678), "R11");

      for (int i = 0; i < 3000; i++) begin
         bit s, p, q, c;
         logic [31:0] d;
         s = ($urandom % 4) == 0;
         p = ($urandom % 4) == 0;
         q = ($urandom % 3) == 0;
         c = ($urandom % 5) == 0;
         d = $urandom;
         step(s, p, q, c, d, "R9/R10 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule